// File: doc/BRIEF.md
# Sparse Hit Readout Engine

This block drains a parallel bank of front-end channels onto a narrow output bus and sends only the channels that recorded a hit. A one-cycle start pulse captures a hit mask and one digitized value for every channel. The engine then scans the captured mask in ascending channel order. For each hit it emits two words on the bus. When nothing unread remains, it raises a one-cycle done flag.

Empty channels are skipped while the readout runs. There is no compaction pass before it. The channels are split into fixed-size groups, and each group has an OR-reduced occupancy flag. Hits inside one group go out back to back. Moving to the next occupied group costs one idle bus cycle, however far apart the two groups are. Because of that bound, readout time depends on the number of hits and occupied groups, not on the channel count.

Top module: `sro_readout`

## Requirements
- R1: An edge on which `start` is high while the engine is idle captures `hit_in` and `data_in`. Later changes on those inputs do not alter the readout in progress.
- R2: Each hit channel produces two consecutive valid words. The first is the channel number zero-extended to the bus width, with `out_addr` = 1. The second is that channel's captured value, with `out_addr` = 0.
- R3: Channels without a hit produce no words. Each hit channel is sent exactly once per readout.
- R4: Hit channels are sent in strictly ascending channel-number order.
- R5: `done` is high in the cycle that follows the (2H+G+1)-th rising edge after the edge that sampled `start`. H is the number of captured hits. G is the number of occupied groups, where channel c belongs to group c/16 by default. With no hits this is the cycle after the first edge.
- R6: `done` lasts exactly one cycle and is never high together with `out_valid`.
- R7: A `start` pulse that arrives while a readout is in progress is ignored.
- R8: While `rst` is high, the next edge clears `out_valid` and `done`, drops any readout in progress and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse: capture inputs and begin a readout |
| hit_in | input | NCH | Per-channel hit flags |
| data_in | input | NCH*DW | Per-channel values; channel c occupies bits c*DW +: DW |
| out_valid | output | 1 | Bus word valid |
| out_addr | output | 1 | High when the bus word is a channel number |
| out_data | output | DW | Bus word |
| done | output | 1 | One-cycle end-of-readout flag |

## Verification
The bench aims at the pattern edges:
- An empty mask: a design that mishandles it would hang, or would emit a stray word before `done`.
- Single hits on the first and last channel: an off-by-one encoder would drop or misnumber these.
- A fully occupied mask: a scanner that restarts or double-counts would break the exact 2H+G+1 cycle budget.
- Two hits in widely separated groups: this shows whether a group jump costs exactly one bubble or several.

The inputs are scrambled right after capture. A `start` pulse is injected mid-readout. A reset is asserted mid-readout. Together these expose a design that reads live inputs, restarts on a second pulse, or keeps driving words through reset.

// File: rtl/sro_pkg.sv
package sro_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEEK = 2'd1,
      ST_ADDR = 2'd2,
      ST_DATA = 2'd3
   } sro_state_e;
endpackage

// File: rtl/sro_capture.sv
module sro_capture #(
   parameter int NCH = 128,
   parameter int DW  = 8,
   parameter int AW  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [NCH-1:0]    hit_in,
   input  logic [NCH*DW-1:0] data_in,
   input  logic              clr_en,
   input  logic [AW-1:0]     clr_idx,
   input  logic [AW-1:0]     rd_idx,
   output logic [NCH-1:0]    mask_q,
   output logic [DW-1:0]     rd_data
);
   logic [NCH*DW-1:0] data_q;

   // pending-hit mask: loaded on capture, bits retired as they are sent
   always_ff @(posedge clk) begin
      if (rst)
         mask_q <= '0;
      else if (load)
         mask_q <= hit_in;
      else if (clr_en)
         mask_q[clr_idx] <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (load)
         data_q <= data_in;
   end

   assign rd_data = data_q[rd_idx*DW +: DW];
endmodule

// File: rtl/sro_group_scan.sv
module sro_group_scan #(
   parameter int NCH = 128,
   parameter int GRP = 16,
   parameter int NG  = 8,
   parameter int GW  = 4,
   parameter int GIW = 3
) (
   input  logic [NCH-1:0] mask,
   input  logic [GIW-1:0] cur_g,
   output logic           any_hit,
   output logic [GIW-1:0] first_g,
   output logic [GW-1:0]  lo_idx,
   output logic           more_in_grp
);
   logic [NG-1:0]  grp_any;
   logic [GRP-1:0] cur_bits;

   for (genvar g = 0; g < NG; g++) begin : g_occ
      assign grp_any[g] = |mask[g*GRP +: GRP];
   end

   assign any_hit  = |grp_any;
   assign cur_bits = mask[cur_g*GRP +: GRP];

   // lowest occupied group
   always_comb begin
      first_g = '0;
      for (int i = NG-1; i >= 0; i--)
         if (grp_any[i]) first_g = GIW'(i);
   end

   // lowest pending channel inside the current group
   always_comb begin
      lo_idx = '0;
      for (int i = GRP-1; i >= 0; i--)
         if (cur_bits[i]) lo_idx = GW'(i);
   end

   // two or more bits set: another hit remains after the lowest is retired
   assign more_in_grp = |(cur_bits & (cur_bits - GRP'(1)));
endmodule

// File: rtl/sro_out_seq.sv
module sro_out_seq
   import sro_pkg::*;
#(
   parameter int DW  = 8,
   parameter int AW  = 7,
   parameter int GW  = 4,
   parameter int GIW = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           any_hit,
   input  logic [GIW-1:0] first_g,
   input  logic [GW-1:0]  lo_idx,
   input  logic           more_in_grp,
   input  logic [DW-1:0]  rd_data,
   output logic [GIW-1:0] g_q,
   output logic           load,
   output logic           clr_en,
   output logic [AW-1:0]  ch_idx,
   output logic           out_valid,
   output logic           out_addr,
   output logic [DW-1:0]  out_data,
   output logic           done
);
   sro_state_e state;

   assign load   = (state == ST_IDLE) && start;
   assign clr_en = (state == ST_DATA);
   assign ch_idx = {g_q, lo_idx};

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         g_q       <= '0;
         out_valid <= 1'b0;
         out_addr  <= 1'b0;
         out_data  <= '0;
         done      <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_addr  <= 1'b0;
         done      <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) state <= ST_SEEK;
            end
            ST_SEEK: begin
               if (any_hit) begin
                  g_q   <= first_g;
                  state <= ST_ADDR;
               end else begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_ADDR: begin
               out_valid <= 1'b1;
               out_addr  <= 1'b1;
               out_data  <= DW'(ch_idx);
               state     <= ST_DATA;
            end
            ST_DATA: begin
               out_valid <= 1'b1;
               out_data  <= rd_data;
               state     <= more_in_grp ? ST_ADDR : ST_SEEK;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sro_readout.sv
module sro_readout #(
   parameter int NCH = 128,
   parameter int DW  = 8,
   parameter int GRP = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [NCH-1:0]    hit_in,
   input  logic [NCH*DW-1:0] data_in,
   output logic              out_valid,
   output logic              out_addr,
   output logic [DW-1:0]     out_data,
   output logic              done
);
   localparam int AW  = $clog2(NCH);
   localparam int GW  = $clog2(GRP);
   localparam int NG  = NCH / GRP;
   localparam int GIW = $clog2(NG);

   initial begin
      if ((1 << GW) != GRP || GRP < 2)
         $error("sro_readout: GRP must be a power of two >= 2");
      if (NG < 2 || (1 << GIW) != NG || NG * GRP != NCH)
         $error("sro_readout: NCH must be a power-of-two multiple (>=2) of GRP");
      if (AW > DW)
         $error("sro_readout: channel number does not fit the bus width");
   end

   logic [NCH-1:0] mask;
   logic           any_hit, more_in_grp, load, clr_en;
   logic [GIW-1:0] first_g, g_q;
   logic [GW-1:0]  lo_idx;
   logic [AW-1:0]  ch_idx;
   logic [DW-1:0]  rd_data;

   sro_capture #(.NCH(NCH), .DW(DW), .AW(AW)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .hit_in  (hit_in),
      .data_in (data_in),
      .clr_en  (clr_en),
      .clr_idx (ch_idx),
      .rd_idx  (ch_idx),
      .mask_q  (mask),
      .rd_data (rd_data)
   );

   sro_group_scan #(.NCH(NCH), .GRP(GRP), .NG(NG), .GW(GW), .GIW(GIW)) u_scan (
      .mask        (mask),
      .cur_g       (g_q),
      .any_hit     (any_hit),
      .first_g     (first_g),
      .lo_idx      (lo_idx),
      .more_in_grp (more_in_grp)
   );

   sro_out_seq #(.DW(DW), .AW(AW), .GW(GW), .GIW(GIW)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .any_hit     (any_hit),
      .first_g     (first_g),
      .lo_idx      (lo_idx),
      .more_in_grp (more_in_grp),
      .rd_data     (rd_data),
      .g_q         (g_q),
      .load        (load),
      .clr_en      (clr_en),
      .ch_idx      (ch_idx),
      .out_valid   (out_valid),
      .out_addr    (out_addr),
      .out_data    (out_data),
      .done        (done)
   );
endmodule

// File: rtl/sro_readout_chk.sv
module sro_readout_chk #(
   parameter int NCH = 128,
   parameter int DW  = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          out_valid,
   input logic          out_addr,
   input logic [DW-1:0] out_data,
   input logic          done
);
   localparam logic [DW:0] LIMIT = (DW+1)'(NCH);

   logic          have_prev;
   logic [DW-1:0] prev_addr;

   always_ff @(posedge clk) begin
      if (rst || done) begin
         have_prev <= 1'b0;
         prev_addr <= '0;
      end else if (out_valid && out_addr) begin
         have_prev <= 1'b1;
         prev_addr <= out_data;
      end
   end

   AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_addr |=> out_valid && !out_addr); // R2
   AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_addr |-> $past(out_valid && out_addr)); // R2
   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_addr |-> {1'b0, out_data} < LIMIT); // R2
   AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_addr && have_prev |-> out_data > prev_addr); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R6
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      done |-> !out_valid); // R6
endmodule

bind sro_readout sro_readout_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_addr  (out_addr),
   .out_data  (out_data),
   .done      (done)
);

// File: tb/sro_readout_tb.sv
module sro_readout_tb;
   localparam int NCH = 128;
   localparam int DW  = 8;
   localparam int GRP = 16;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic [NCH-1:0]    hit_in = '0;
   logic [NCH*DW-1:0] data_in = '0;
   logic              out_valid, out_addr, done;
   logic [DW-1:0]     out_data;

   int checks = 0;
   int errors = 0;
   logic [DW:0] exp_q[$];
   logic [DW:0] exp_w;

   always #4 clk = ~clk;

   sro_readout #(.NCH(NCH), .DW(DW), .GRP(GRP)) u_dut (
      .clk (clk), .rst (rst), .start (start), .hit_in (hit_in), .data_in (data_in),
      .out_valid (out_valid), .out_addr (out_addr), .out_data (out_data), .done (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // monitor: pop and compare every valid word (R2, R3, R4)
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R3 unexpected word actual=%0h expected=none", {out_addr, out_data});
         end else begin
            exp_w = exp_q.pop_front();
            check({out_addr, out_data} === exp_w, "R2/R4 word", int'({out_addr, out_data}), int'(exp_w));
         end
      end
   end

   // driver: capture, scramble inputs, await done, check cycle budget
   task automatic run(input logic [NCH-1:0] pat, input bit poke);
      int h = 0;
      int g = 0;
      int n = 0;
      for (int c = 0; c < NCH; c++) data_in[c*DW +: DW] = DW'($urandom);
      hit_in = pat;
      for (int c = 0; c < NCH; c++)
         if (pat[c]) begin
            h++;
            exp_q.push_back({1'b1, DW'(c)});
            exp_q.push_back({1'b0, data_in[c*DW +: DW]});
         end
      for (int k = 0; k < NCH/GRP; k++) if (|pat[k*GRP +: GRP]) g++;
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      // R1: inputs change after capture and must not matter
      for (int k = 0; k < NCH/32; k++) hit_in[k*32 +: 32] = $urandom;
      for (int c = 0; c < NCH; c++) data_in[c*DW +: DW] = DW'($urandom);
      forever begin
         @(posedge clk);
         n++;
         @(negedge clk);
         start = poke && (n == 3); // R7: pulse while busy
         if (done || n > 2000) break;
      end
      start = 1'b0;
      check(n == 2*h + g + 1, "R5 done latency", n, 2*h + g + 1);
      check(exp_q.size() == 0, "R3 words missing", exp_q.size(), 0);
      exp_q.delete();
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", int'(done), 0);
      check(out_valid == 1'b0, "R7 no restart after done", int'(out_valid), 0);
   endtask

   function automatic logic [NCH-1:0] rand_pat(input bit dense);
      logic [NCH-1:0] p;
      for (int k = 0; k < NCH/32; k++)
         p[k*32 +: 32] = dense ? ($urandom | $urandom) : ($urandom & $urandom & $urandom);
      return p;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_sim();
   end

   initial begin
      logic [NCH-1:0] p;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && done == 1'b0, "R8 reset state", int'({out_valid, done}), 0);
      rst = 1'b0;
      @(negedge clk);

      run('0, 1'b0);                                   // empty
      run({NCH{1'b1}}, 1'b0);                          // full
      run(NCH'(1), 1'b0);                              // first channel only
      run({1'b1, {(NCH-1){1'b0}}}, 1'b0);              // last channel only
      p = '0; p[3] = 1'b1; p[120] = 1'b1;
      run(p, 1'b0);                                    // distant group jump
      p = '0; p[31:16] = '1;
      run(p, 1'b0);                                    // one full group
      p = '0; for (int c = 0; c < NCH; c += 2) p[c] = 1'b1;
      run(p, 1'b1);                                    // alternating, start mid-run (R7)
      for (int i = 0; i < 8; i++) run(rand_pat(1'b0), i[0]);
      for (int i = 0; i < 3; i++) run(rand_pat(1'b1), 1'b0);

      // R8: reset in the middle of a readout
      for (int c = 0; c < NCH; c++) data_in[c*DW +: DW] = DW'(c);
      hit_in = '1;
      for (int c = 0; c < NCH; c++) begin
         exp_q.push_back({1'b1, DW'(c)});
         exp_q.push_back({1'b0, DW'(c)});
      end
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (8) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      exp_q.delete();
      check(out_valid == 1'b0 && done == 1'b0, "R8 reset aborts", int'({out_valid, done}), 0);
      @(negedge clk);
      rst = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check(out_valid == 1'b0 && done == 1'b0, "R8 stays idle", int'({out_valid, done}), 0);
      end
      p = '0; p[77] = 1'b1; p[78] = 1'b1;
      run(p, 1'b0);
      finish_sim();
   end
endmodule